// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit integer pipeline and a 32-bit word-addressed data memory. On the store side it accepts a request stream that carries an already-summed effective address, the source register value and an access size. It produces a write stream to memory. That stream carries the word-aligned address, four byte strobes and the store value copied across every lane of its size, so that only the strobed lanes land in memory.

On the load side it accepts the 32-bit word returned by memory, together with the low two address bits, the access size and a signedness flag. It returns the addressed byte, halfword or word, sign-extended or zero-extended to 32 bits.

The byte numbering inside a word is big-endian or little-endian. The mode is sampled from a configuration pin while reset is held and stays fixed until the next reset. A misaligned access raises an error flag. A misaligned store never reaches memory.

Both streams use valid/ready. A store request is consumed when `st_ready` is high in a cycle with `st_valid` high. For an aligned request, `st_ready` follows `mem_wready`, so back-pressure from memory stalls the pipeline. A misaligned or reserved-size request is consumed at once without a memory write. The load path passes `ld_ready` straight back as `ld_rready`. While ready is low, the producer must hold valid and its payload steady.

Top module: `lsa_top`

## Requirements
- R1: Size code 2 (word): when `mem_wvalid` is high, `mem_waddr` equals `st_addr` with bits 1:0 cleared, `mem_wstrb` is 4'b1111 and `mem_wdata` equals `st_data`.
- R2: Size code 1 (halfword) at an even address: `mem_wdata` is `st_data[15:0]` repeated twice. Exactly two strobes are set: the lanes holding byte offsets a and a+1.
- R3: Size code 0 (byte): `mem_wdata` is `st_data[7:0]` repeated four times. Exactly one strobe is set: the lane of the addressed offset.
- R4: In big-endian mode, byte offset o lives in lane 3-o, so offset 0 is data bits 31:24. Within a halfword, the lower offset holds the most significant byte.
- R5: In little-endian mode, byte offset o lives in lane o, so offset 0 is data bits 7:0. Within a halfword, the lower offset holds the least significant byte.
- R6: The endian mode is taken from `cfg_big_endian` while `rst_n` is low. Changing the pin after reset has no effect on lane mapping.
- R7: A store is misaligned when it is a halfword with address bit 0 set, a word with address bits 1:0 non-zero, or size code 3. For such a store, `st_addr_err` is high, `mem_wvalid` is low, `mem_wstrb` is zero and `st_ready` is high regardless of `mem_wready`.
- R8: A byte load returns the addressed byte. It is sign-extended when `ld_unsigned` is 0 and zero-extended when it is 1.
- R9: A halfword load returns the addressed 16-bit value. It is sign-extended when `ld_unsigned` is 0 and zero-extended when it is 1.
- R10: A word load returns the memory word unchanged. A misaligned load (same rule as R7) raises `ld_addr_err` and returns zero.
- R11: For an aligned store, `mem_wvalid` follows `st_valid` and `st_ready` follows `mem_wready`. On the load side, `ld_valid` follows `ld_rvalid` and `ld_rready` follows `ld_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; endian mode sampled while low |
| cfg_big_endian | input | 1 | 1 = big-endian byte numbering, 0 = little-endian |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted |
| st_addr | input | 32 | Effective byte address of the store |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| st_data | input | 32 | Source register value |
| st_addr_err | output | 1 | Store request is misaligned or has reserved size |
| mem_wvalid | output | 1 | Memory write valid |
| mem_wready | input | 1 | Memory accepts write |
| mem_waddr | output | 32 | Word-aligned write address |
| mem_wstrb | output | 4 | Byte-lane strobes, bit i covers data bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-replicated write data |
| ld_rvalid | input | 1 | Memory read word valid |
| ld_rready | output | 1 | Unit accepts read word |
| ld_rword | input | 32 | Word returned by memory |
| ld_off | input | 2 | Low two bits of the load effective address |
| ld_size | input | 2 | Load size, same code as st_size |
| ld_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Pipeline accepts load result |
| ld_result | output | 32 | Extended load value |
| ld_addr_err | output | 1 | Load is misaligned or has reserved size |

## Verification
The assertions check the following on every cycle:
- writes leave with a cleared low address and a strobe count that matches the size;
- misaligned or reserved stores never raise `mem_wvalid` and are always accepted;
- sub-word loads carry correct extension bits in their upper result bits;
- the latched mode never moves after reset.

Which lane a given offset lands in under each endian mode, which half of the source value feeds which lane, and the locking of the mode against a later pin change are shown only by the bench scenarios. These compare the outputs against values worked out from the lane rules for every offset, size and mode.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DATA_W = 32;
  localparam int NLANES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NLANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // True when the access cannot be served in one aligned memory word.
  function automatic logic is_misaligned(acc_size_e sz, logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      SZ_WORD: return |off;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/lsa_mode_reg.sv
module lsa_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_in,
  output logic big_q
);
  // Captured only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) big_q <= mode_in;
  end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import lsa_pkg::*;
(
  input  logic              big,
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] src,
  output logic [NLANES-1:0] strb,
  output logic [DATA_W-1:0] wdata
);
  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [OFF_W-1:0] idx;   // byte offset this lane represents
    logic             en;
    logic [7:0]       bval;

    assign idx = OFF_W'(i) ^ {OFF_W{big}};

    always_comb begin
      case (size)
        SZ_BYTE: begin
          en   = (idx == off);
          bval = src[7:0];
        end
        SZ_HALF: begin
          en   = (idx[OFF_W-1:1] == off[OFF_W-1:1]);
          bval = (idx[0] ^ big) ? src[15:8] : src[7:0];
        end
        SZ_WORD: begin
          en   = 1'b1;
          bval = src[8*i +: 8];
        end
        default: begin
          en   = 1'b0;
          bval = src[8*i +: 8];
        end
      endcase
    end

    assign strb[i]          = en;
    assign wdata[8*i +: 8]  = bval;
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  logic              big,
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic              uns,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  logic [OFF_W-1:0] lane;
  logic [7:0]       bsel;
  logic [15:0]      hsel;

  assign lane = off ^ {OFF_W{big}};
  assign bsel = word[8*lane +: 8];
  assign hsel = (big ^ off[OFF_W-1]) ? word[31:16] : word[15:0];

  always_comb begin
    case (size)
      SZ_BYTE: result = uns ? {24'b0, bsel} : {{24{bsel[7]}}, bsel};
      SZ_HALF: result = uns ? {16'b0, hsel} : {{16{hsel[15]}}, hsel};
      SZ_WORD: result = word;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_addr_err,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [NLANES-1:0] mem_wstrb,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              ld_rvalid,
  output logic              ld_rready,
  input  logic [DATA_W-1:0] ld_rword,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [1:0]        ld_size,
  input  logic              ld_unsigned,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [DATA_W-1:0] ld_result,
  output logic              ld_addr_err
);
  logic              big_q;
  acc_size_e         st_sz, ld_sz;
  logic [OFF_W-1:0]  st_off;
  logic              st_bad, ld_bad;
  logic [NLANES-1:0] raw_strb;
  logic [DATA_W-1:0] raw_result;

  assign st_sz  = acc_size_e'(st_size);
  assign ld_sz  = acc_size_e'(ld_size);
  assign st_off = st_addr[OFF_W-1:0];
  assign st_bad = is_misaligned(st_sz, st_off);
  assign ld_bad = is_misaligned(ld_sz, ld_off);

  lsa_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (cfg_big_endian),
    .big_q   (big_q)
  );

  lsa_store_lanes u_st (
    .big   (big_q),
    .off   (st_off),
    .size  (st_sz),
    .src   (st_data),
    .strb  (raw_strb),
    .wdata (mem_wdata)
  );

  lsa_load_extract u_ld (
    .big    (big_q),
    .off    (ld_off),
    .size   (ld_sz),
    .uns    (ld_unsigned),
    .word   (ld_rword),
    .result (raw_result)
  );

  // Store stream: bad requests are dropped and consumed immediately.
  assign mem_waddr   = {st_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wstrb   = st_bad ? '0 : raw_strb;
  assign mem_wvalid  = st_valid & ~st_bad;
  assign st_ready    = st_bad | mem_wready;
  assign st_addr_err = st_valid & st_bad;

  // Load stream: pure pass-through handshake.
  assign ld_valid    = ld_rvalid;
  assign ld_rready   = ld_ready;
  assign ld_result   = ld_bad ? '0 : raw_result;
  assign ld_addr_err = ld_rvalid & ld_bad;
endmodule

// File: rtl/lsa_chk.sv
module lsa_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        big_q,
  input logic        st_valid,
  input logic        st_ready,
  input logic [31:0] st_addr,
  input logic [1:0]  st_size,
  input logic [31:0] st_data,
  input logic        st_addr_err,
  input logic        mem_wvalid,
  input logic        mem_wready,
  input logic [31:0] mem_waddr,
  input logic [3:0]  mem_wstrb,
  input logic [31:0] mem_wdata,
  input logic        ld_valid,
  input logic [1:0]  ld_size,
  input logic        ld_unsigned,
  input logic [31:0] ld_result,
  input logic        ld_addr_err
);
  logic st_misal;
  assign st_misal = (st_size == 2'd3) || (st_size == 2'd2 && st_addr[1:0] != 2'd0)
                  || (st_size == 2'd1 && st_addr[0]);

  assert_waddr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (mem_waddr == {st_addr[31:2], 2'b00}));

  assert_word_all_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && st_size == 2'd2) |-> (mem_wstrb == 4'hf && mem_wdata == st_data));

  assert_half_two_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && st_size == 2'd1) |-> ($countones(mem_wstrb) == 2
      && mem_wdata == {2{st_data[15:0]}}));

  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && st_size == 2'd0) |-> ($countones(mem_wstrb) == 1
      && mem_wdata == {4{st_data[7:0]}}));

  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(big_q));

  assert_misaligned_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_misal) |-> (!mem_wvalid && st_ready && st_addr_err && mem_wstrb == 4'h0));

  assert_byte_extend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size == 2'd0) |->
      (ld_unsigned ? (ld_result[31:8] == 24'h0) : (ld_result[31:8] == {24{ld_result[7]}})));

  assert_half_extend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size == 2'd1 && !ld_addr_err) |->
      (ld_unsigned ? (ld_result[31:16] == 16'h0) : (ld_result[31:16] == {16{ld_result[15]}})));

  assert_load_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_addr_err) |-> (ld_result == 32'h0));

  assert_store_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_misal) |-> (mem_wvalid && st_ready == mem_wready));
endmodule

bind lsa_top lsa_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .big_q       (big_q),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .st_addr     (st_addr),
  .st_size     (st_size),
  .st_data     (st_data),
  .st_addr_err (st_addr_err),
  .mem_wvalid  (mem_wvalid),
  .mem_wready  (mem_wready),
  .mem_waddr   (mem_waddr),
  .mem_wstrb   (mem_wstrb),
  .mem_wdata   (mem_wdata),
  .ld_valid    (ld_valid),
  .ld_size     (ld_size),
  .ld_unsigned (ld_unsigned),
  .ld_result   (ld_result),
  .ld_addr_err (ld_addr_err)
);

// File: tb/sim_lsa_top.sv
module sim_lsa_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic [31:0] st_data = '0;
  logic        st_addr_err;
  logic        mem_wvalid, mem_wready = 1'b1;
  logic [31:0] mem_waddr;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata;
  logic        ld_rvalid = 1'b0, ld_rready;
  logic [31:0] ld_rword = '0;
  logic [1:0]  ld_off = '0;
  logic [1:0]  ld_size = '0;
  logic        ld_unsigned = 1'b0;
  logic        ld_valid, ld_ready = 1'b1;
  logic [31:0] ld_result;
  logic        ld_addr_err;

  int n_checks = 0;
  int n_fail   = 0;
  logic mode_be = 1'b0;   // bench's own copy of the mode it reset with

  always #2 clk = ~clk;   // 250 MHz

  lsa_top u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int lane_of(logic be, int o);
    return be ? 3 - o : o;
  endfunction

  task automatic do_reset(logic be);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_big_endian = be;
    mode_be = be;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one aligned store and compare against the lane rules.
  task automatic store_one(string req, logic [31:0] a, logic [1:0] sz, logic [31:0] d);
    logic [3:0]  es;
    logic [31:0] ed;
    int o;
    o = int'(a[1:0]);
    es = '0;
    case (sz)
      2'd0: begin es[lane_of(mode_be, o)] = 1'b1; ed = {4{d[7:0]}}; end
      2'd1: begin es[lane_of(mode_be, o)] = 1'b1; es[lane_of(mode_be, o + 1)] = 1'b1;
                  ed = {2{d[15:0]}}; end
      default: begin es = 4'hf; ed = d; end
    endcase
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d;
    #1;
    check({req, " wvalid"}, 32'(mem_wvalid), 32'd1);
    check({req, " waddr"}, mem_waddr, {a[31:2], 2'b00});
    check({req, " strb"}, 32'(mem_wstrb), 32'(es));
    check({req, " wdata"}, mem_wdata, ed);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic load_one(string req, logic [31:0] w, logic [1:0] o, logic [1:0] sz, logic u);
    logic [7:0]  b0, b1;
    logic [15:0] h;
    logic [31:0] exp;
    b0 = w[8*lane_of(mode_be, int'(o)) +: 8];
    b1 = w[8*lane_of(mode_be, (int'(o) + 1) % 4) +: 8];
    h  = mode_be ? {b0, b1} : {b1, b0};
    case (sz)
      2'd0: exp = u ? {24'h0, b0} : {{24{b0[7]}}, b0};
      2'd1: exp = u ? {16'h0, h} : {{16{h[15]}}, h};
      default: exp = w;
    endcase
    @(negedge clk);
    ld_rvalid = 1'b1; ld_rword = w; ld_off = o; ld_size = sz; ld_unsigned = u;
    #1;
    check({req, " ld_valid"}, 32'(ld_valid), 32'd1);
    check({req, " ld_err"}, 32'(ld_addr_err), 32'd0);
    check({req, " ld_result"}, ld_result, exp);
    @(negedge clk);
    ld_rvalid = 1'b0;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 reset wvalid", 32'(mem_wvalid), 32'd0);
    check("R11 reset ld_valid", 32'(ld_valid), 32'd0);
    check("R7 reset err", 32'(st_addr_err), 32'd0);
  endtask

  task automatic t_store_word;
    store_one("R1 word", 32'h0000_1000, 2'd2, 32'hA1B2_C3D4);
    store_one("R1 word hi", 32'hFFFF_FFFC, 2'd2, 32'h0123_4567);
  endtask

  task automatic t_store_half;
    for (int o = 0; o < 4; o += 2)
      store_one("R2 half", 32'h0000_2000 + o, 2'd1, 32'hDEAD_BEEF);
  endtask

  task automatic t_store_byte;
    for (int o = 0; o < 4; o++)
      store_one("R3 byte", 32'h0000_3000 + o, 2'd0, 32'h1234_56A5 + o);
  endtask

  // Fixed-value lane mapping spot checks for each mode.
  task automatic t_lane_fixed;
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h40; st_size = 2'd0; st_data = 32'h77;
    #1;
    if (mode_be) check("R4 BE offset0 lane", 32'(mem_wstrb), 32'h8);
    else         check("R5 LE offset0 lane", 32'(mem_wstrb), 32'h1);
    st_addr = 32'h42; st_size = 2'd1;
    #1;
    if (mode_be) check("R4 BE half at 2", 32'(mem_wstrb), 32'h3);
    else         check("R5 LE half at 2", 32'(mem_wstrb), 32'hC);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic t_misaligned;
    logic [31:0] a [3] = '{32'h51, 32'h52, 32'h50};
    logic [1:0]  s [3] = '{2'd1, 2'd2, 2'd3};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      mem_wready = 1'b0;
      st_valid = 1'b1; st_addr = a[k]; st_size = s[k]; st_data = 32'hFFFF_FFFF;
      #1;
      check("R7 err", 32'(st_addr_err), 32'd1);
      check("R7 no write", 32'(mem_wvalid), 32'd0);
      check("R7 strb zero", 32'(mem_wstrb), 32'd0);
      check("R7 consumed", 32'(st_ready), 32'd1);
    end
    @(negedge clk);
    st_valid = 1'b0; mem_wready = 1'b1;
  endtask

  task automatic t_mode_locked;
    @(negedge clk);
    cfg_big_endian = ~mode_be;
    repeat (3) @(posedge clk);
    store_one("R6 locked byte", 32'h0000_0060, 2'd0, 32'h0000_00C3);
    load_one("R6 locked load", 32'h1122_3344, 2'd0, 2'd0, 1'b1);
    @(negedge clk);
    cfg_big_endian = mode_be;
  endtask

  task automatic t_load_byte;
    for (int o = 0; o < 4; o++) begin
      load_one("R8 lb", 32'h80F1_7F02, 2'(o), 2'd0, 1'b0);
      load_one("R8 lbu", 32'h80F1_7F02, 2'(o), 2'd0, 1'b1);
    end
  endtask

  task automatic t_load_half;
    for (int o = 0; o < 4; o += 2) begin
      load_one("R9 lh", 32'h8001_7FFE, 2'(o), 2'd1, 1'b0);
      load_one("R9 lhu", 32'h8001_7FFE, 2'(o), 2'd1, 1'b1);
    end
  endtask

  task automatic t_load_word_err;
    load_one("R10 lw", 32'hCAFE_F00D, 2'd0, 2'd2, 1'b0);
    @(negedge clk);
    ld_rvalid = 1'b1; ld_rword = 32'hFFFF_FFFF; ld_off = 2'd1; ld_size = 2'd1;
    #1;
    check("R10 misaligned lh err", 32'(ld_addr_err), 32'd1);
    check("R10 misaligned lh zero", ld_result, 32'd0);
    ld_off = 2'd2; ld_size = 2'd2;
    #1;
    check("R10 misaligned lw err", 32'(ld_addr_err), 32'd1);
    @(negedge clk);
    ld_rvalid = 1'b0;
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    mem_wready = 1'b0; ld_ready = 1'b0;
    st_valid = 1'b1; st_addr = 32'h80; st_size = 2'd2; st_data = 32'h5;
    ld_rvalid = 1'b1; ld_size = 2'd2; ld_off = 2'd0;
    #1;
    check("R11 stall st_ready", 32'(st_ready), 32'd0);
    check("R11 stall wvalid", 32'(mem_wvalid), 32'd1);
    check("R11 stall ld_rready", 32'(ld_rready), 32'd0);
    mem_wready = 1'b1; ld_ready = 1'b1;
    #1;
    check("R11 release st_ready", 32'(st_ready), 32'd1);
    check("R11 release ld_rready", 32'(ld_rready), 32'd1);
    @(negedge clk);
    st_valid = 1'b0; ld_rvalid = 1'b0;
  endtask

  task automatic run_mode(logic be);
    do_reset(be);
    t_store_word();
    t_store_half();
    t_store_byte();
    t_lane_fixed();
    t_misaligned();
    t_mode_locked();
    t_load_byte();
    t_load_half();
    t_load_word_err();
    t_backpressure();
  endtask

  initial begin
    t_reset_state();
    run_mode(1'b1);
    run_mode(1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule